// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block is a one-shot watchdog timer. Software controls it through a single byte-wide control register. Bits [6:2] of the register hold a 5-bit multiplier and bits [1:0] hold a 2-bit resolution. Together they set a timeout of `multiplier × 4^resolution` periods of a 16 Hz tick enable. Bit 7 is a steering bit that picks what an expiry does: it either raises a one-cycle reset request or produces a one-cycle interrupt pulse.

Software keeps the watchdog from expiring by restarting the countdown. Two actions restart it:
- writing the control register, which also stores the new setting;
- reading the flags register, which reloads the count from the stored setting.

Both actions clear the watchdog flag. An expiry sets the flag, and the flag stays set until the next restart. The flags register cannot be written from the bus, so the flag can be cleared only by a restart. A multiplier of zero leaves the countdown idle, which disables the watchdog.

Top module: `wdog_steer`

## Requirements
- R1: After a synchronous active-low reset, the stored control value is 0x00, the flag is 0 and neither output pulses.
- R2: After a restart, expiry occurs on exactly the N-th tick-enable cycle, where N = cfg[6:2] × 4^cfg[1:0]. The outputs show the expiry in the cycle after that tick.
- R3: A control write stores the byte, which is visible on `cfg_q` the next cycle, clears the flag and restarts the countdown from the new value.
- R4: A flags-register read clears the flag and restarts the countdown from the stored control value.
- R5: Every expiry sets `wd_flag`. The flag then holds until the next restart.
- R6: If bit 7 is 1 at expiry, `rst_req` is high for exactly one cycle, the stored control value becomes 0x00 in that same cycle, and `irq` stays low.
- R7: If bit 7 is 0 at expiry, `irq` is high for exactly one cycle, the stored control value is kept, and `rst_req` stays low.
- R8: A multiplier of zero never expires, whatever the resolution.
- R9: After an expiry the watchdog is idle, and it produces no further pulse until a restart.
- R10: A restart in the same cycle as the final tick wins, so no expiry occurs.
- R11: The countdown advances only in cycles where `tick_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | 16 Hz count enable, one cycle wide |
| cfg_wr | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 8 | Control byte to write |
| flag_rd | input | 1 | Strobe marking a read of the flags register |
| cfg_q | output | 8 | Stored control value |
| wd_flag | output | 1 | Watchdog expiry flag |
| rst_req | output | 1 | One-cycle reset request |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions check several properties on every cycle:
- both outputs are single-cycle pulses and never occur together;
- a reset request always coincides with a cleared control value and a set flag;
- a cycle with a restart or with no tick is never followed by a pulse;
- a write is always followed by the stored byte and a clear flag.

Other behaviour needs whole scenarios, and only the bench's behavioural model can show it: the exact timeout length for each multiplier and resolution up to the 1984-tick maximum, the one-shot idle state after an interrupt expiry, the disabled zero multiplier, and a restart winning against the final tick.

// File: rtl/wdog_steer.sv
module wdog_steer #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              cfg_wr,
  input  logic [MULT_W+RES_W:0] cfg_wdata,
  input  logic              flag_rd,
  output logic [MULT_W+RES_W:0] cfg_q,
  output logic              wd_flag,
  output logic              rst_req,
  output logic              irq
);
  localparam int CFG_W = MULT_W + RES_W + 1;
  localparam int STEER = CFG_W - 1;
  localparam int CNT_W = MULT_W + 2 * ((1 << RES_W) - 1);

  function automatic logic [CNT_W-1:0] span(input logic [CFG_W-1:0] v);
    span = CNT_W'(v[RES_W +: MULT_W]) << (2 * int'(v[RES_W-1:0]));
  endfunction

  logic [CNT_W-1:0] cnt;
  logic             restart, expire;

  assign restart = cfg_wr | flag_rd;
  assign expire  = tick_en && !restart && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      cnt     <= '0;
      wd_flag <= 1'b0;
      rst_req <= 1'b0;
      irq     <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      irq     <= 1'b0;
      if (cfg_wr) begin
        cfg_q   <= cfg_wdata;
        cnt     <= span(cfg_wdata);
        wd_flag <= 1'b0;
      end else if (flag_rd) begin
        cnt     <= span(cfg_q);
        wd_flag <= 1'b0;
      end else if (expire) begin
        cnt     <= '0;
        wd_flag <= 1'b1;
        if (cfg_q[STEER]) begin
          rst_req <= 1'b1;
          cfg_q   <= '0;
        end else begin
          irq <= 1'b1;
        end
      end else if (tick_en && cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_steer_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && irq));
  assert_cfg_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cfg_q == '0));
  assert_flag_on_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || irq) |-> wd_flag);
  assert_write_stores_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_q == $past(cfg_wdata)) && !wd_flag);
  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd |=> !wd_flag);
  assert_restart_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !rst_req && !irq);
  assert_tick_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> !rst_req && !irq);
  assert_zero_mult_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_wdata[RES_W +: MULT_W] == '0) |=> (cnt == '0));
endmodule

// File: tb/tb_wdog_steer.sv
module tb_wdog_steer;
  logic clk = 0, rst_n = 0, tick_en = 0, cfg_wr = 0, flag_rd = 0;
  logic [7:0] cfg_wdata = 0;
  logic [7:0] cfg_q;
  logic wd_flag, rst_req, irq;

  always #2 clk = ~clk;

  wdog_steer dut (.clk, .rst_n, .tick_en, .cfg_wr, .cfg_wdata, .flag_rd,
                  .cfg_q, .wd_flag, .rst_req, .irq);

  int tests = 0, fails = 0;
  string cur_req = "R1";

  // behavioural reference
  logic [7:0] m_cfg; int m_rem; bit m_flag, m_rst, m_irq;
  function automatic int ticks_for(logic [7:0] v);
    return int'(v[6:2]) * (4 ** int'(v[1:0]));
  endfunction
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg <= 0; m_rem <= 0; m_flag <= 0; m_rst <= 0; m_irq <= 0;
    end else begin
      m_rst <= 0; m_irq <= 0;
      if (cfg_wr) begin
        m_cfg <= cfg_wdata; m_rem <= ticks_for(cfg_wdata); m_flag <= 0;
      end else if (flag_rd) begin
        m_rem <= ticks_for(m_cfg); m_flag <= 0;
      end else if (tick_en && m_rem > 0) begin
        m_rem <= m_rem - 1;
        if (m_rem == 1) begin
          m_flag <= 1;
          if (m_cfg[7]) begin m_rst <= 1; m_cfg <= 0; end
          else m_irq <= 1;
        end
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(cfg_q == m_cfg, cur_req, "cfg_q", cfg_q, m_cfg);
    check({wd_flag, rst_req, irq} == {m_flag, m_rst, m_irq}, cur_req,
          "flag/rst/irq", {wd_flag, rst_req, irq}, {m_flag, m_rst, m_irq});
  end

  task automatic cyc(bit t, bit w = 0, logic [7:0] d = 0, bit r = 0);
    @(negedge clk); tick_en = t; cfg_wr = w; cfg_wdata = d; flag_rd = r;
    @(posedge clk); #1; tick_en = 0; cfg_wr = 0; flag_rd = 0;
  endtask

  // tick every cycle until a pulse; return number of ticks (0 if none within max)
  task automatic run_until(int max, output int n);
    n = 0;
    for (int i = 1; i <= max; i++) begin
      cyc(1);
      if (rst_req || irq) begin n = i; return; end
    end
  endtask

  int n, pulses;
  bit timed_out = 0;

  initial begin
    #400000;
    timed_out = 1;
  end

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1;
        check(cfg_q == 0 && !wd_flag && !rst_req && !irq, "R1", "reset state",
              {cfg_q, wd_flag, rst_req, irq}, 0);
        rst_n = 1;

        cur_req = "R2";
        cyc(0, 1, 8'h06);
        run_until(40, n);
        check(n == 16, "R2", "ticks to expiry 0x06", n, 16);
        check(irq && !rst_req, "R7", "irq path", {rst_req, irq}, 1);
        check(cfg_q == 8'h06, "R7", "cfg kept", cfg_q, 8'h06);
        check(wd_flag, "R5", "flag set", wd_flag, 1);
        cyc(0);
        check(!irq && wd_flag, "R5", "single pulse, flag held", {irq, wd_flag}, 1);

        cur_req = "R9";
        pulses = 0;
        for (int i = 0; i < 40; i++) begin cyc(1); pulses += (irq | rst_req); end
        check(pulses == 0, "R9", "idle after expiry", pulses, 0);

        cur_req = "R4";
        cyc(0, 0, 0, 1);
        check(!wd_flag, "R4", "read clears flag", wd_flag, 0);
        run_until(40, n);
        check(n == 16, "R4", "read restarts", n, 16);

        cur_req = "R3";
        cyc(0, 1, 8'h05);
        check(!wd_flag && cfg_q == 8'h05, "R3", "write stores, clears",
              {wd_flag, cfg_q}, 8'h05);

        cur_req = "R11";
        pulses = 0;
        for (int i = 0; i < 20; i++) begin cyc(0); pulses += irq; end
        cyc(1); cyc(0); cyc(0); cyc(1); cyc(0); cyc(1); pulses += irq;
        check(pulses == 0, "R11", "no expiry before 4 ticks", pulses, 0);
        cyc(0); cyc(0); cyc(1);
        check(irq, "R11", "expiry on 4th tick", irq, 1);

        cur_req = "R6";
        cyc(0, 1, 8'h8D);
        run_until(40, n);
        check(n == 12, "R6", "ticks to reset 0x8D", n, 12);
        check(rst_req && !irq && cfg_q == 0, "R6", "reset path, cfg cleared",
              {rst_req, irq, cfg_q}, 10'h200);
        cyc(1);
        check(!rst_req, "R6", "reset single cycle", rst_req, 0);

        cur_req = "R8";
        cyc(0, 1, 8'h83);
        run_until(300, n);
        check(n == 0, "R8", "zero multiplier never expires", n, 0);

        cur_req = "R10";
        cyc(0, 1, 8'h08);
        cyc(1);
        cyc(1, 0, 0, 1);
        check(!irq, "R10", "restart beats final tick", irq, 0);
        cyc(0);
        check(!irq, "R10", "no late pulse", irq, 0);
        run_until(10, n);
        check(n == 2, "R10", "full reload after restart", n, 2);
        cyc(0, 1, 8'h04);
        cyc(1, 1, 8'h04);
        check(!irq, "R10", "write beats final tick", irq, 0);

        cur_req = "R2";
        cyc(0, 1, 8'h7F);
        run_until(2100, n);
        check(n == 1984, "R2", "maximum timeout", n, 1984);
        cyc(0, 1, 8'h11);
        run_until(40, n);
        check(n == 16, "R2", "mult 4 res 1", n, 16);
      end
      begin
        wait (timed_out);
        check(0, "WDOG", "watchdog expired", 1, 0);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule